// File: doc/BRIEF.md
# Memory card bus cycle controller

This block turns single local requests into external bus cycles for a 16-bit memory card that is reached through two address areas. A request gives the area, the direction, the access size, a 26-bit address and the write data. The block then drives the address, the card enables of the chosen area, the direction line, a one-cycle bus-start pulse, the read or write strobe and the write data. A read returns its data on `rdata_o`, and every cycle ends with a one-cycle `done_o` pulse.

Each area has its own timing register. The register sets how many cycles of address and enable setup come before the strobe, how many software wait cycles stretch the strobe, and how many cycles the address, enables and write data stay driven after the strobe ends. The card can stretch the strobe further by holding `wait_i` high. The controller copies the timing of the chosen area when it accepts a request, so a register write made during a cycle does not affect that cycle.

Top module: `mcard_bus_ctrl`

## Requirements
- R1: Each area has a timing register written through `cfg_we_i`, with `cfg_sel_i` choosing the area (0 or 1). The fields are `cfg_wdata_i[1:0]` setup cycles, `[3:2]` hold cycles and `[5:4]` software wait cycles. After reset every field of both areas is 3.
- R2: `req_ready_o` is high only while no cycle is in progress. A request is taken only on a clock edge where `req_valid_i` and `req_ready_o` are both high. A `req_valid_i` raised during a cycle is ignored.
- R3: The cycle starts in the clock after acceptance. `bs_n_o` is low in exactly that first cycle. `bus_addr_o` holds the request address for the whole cycle, and the strobe stays high for the first `setup` cycles.
- R4: The strobe phase lasts 1 + `wait` cycles when `wait_i` stays low. `rd_n_o` is the strobe for reads and `we_n_o` for writes, and the two are never low together.
- R5: When `wait_i` is high at the clock edge that ends the last strobe cycle, the strobe lasts one more cycle. `wait_i` has no effect in any other cycle.
- R6: After the strobe, `hold` cycles follow. In them the strobes are high while the address, the enables, `rdwr_o` and, for writes, `data_o` with `data_oe_o` high stay driven.
- R7: Read data on `data_i` is captured at the clock edge that ends the strobe. `rdata_o` keeps that value until the next read captures new data, and it is 0 after reset.
- R8: `done_o` is high for exactly one cycle, the first cycle after the hold phase (after the strobe when `hold` is 0). In that cycle `req_ready_o` is high.
- R9: The card enables are active low. Area 0 drives `ce_a_n_o` and area 1 drives `ce_b_n_o`, bit 0 being the low-byte enable and bit 1 the high-byte enable. A 16-bit access asserts both bits. An 8-bit access asserts bit 0 for an even address and bit 1 for an odd address. The enables of the other area stay high.
- R10: The timing of the chosen area is copied at acceptance. A write to its register during the cycle changes only later cycles.
- R11: When idle, all enables, strobes and `bs_n_o` are high, `data_oe_o` is low and `rdwr_o` is high.
- R12: `rdwr_o` is 1 for a read and 0 for a write, and stays constant for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing register write strobe |
| cfg_sel_i | input | 1 | Area whose register is written |
| cfg_wdata_i | input | 6 | {wait, hold, setup}, 2 bits each |
| req_valid_i | input | 1 | Request valid |
| req_area_i | input | 1 | Area of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size16_i | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| req_addr_i | input | 26 | Request address |
| req_wdata_i | input | 16 | Write data |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | One-cycle end-of-cycle pulse |
| rdata_o | output | 16 | Last captured read data |
| bus_addr_o | output | 26 | External address |
| ce_a_n_o | output | 2 | Area 0 card enables, active low |
| ce_b_n_o | output | 2 | Area 1 card enables, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| bs_n_o | output | 1 | Bus start, active low |
| rdwr_o | output | 1 | Direction, 1 = read |
| data_o | output | 16 | Write data to the card |
| data_oe_o | output | 1 | Data bus output enable |
| data_i | input | 16 | Read data from the card |
| wait_i | input | 1 | Card wait request, active high |

## Verification
The bound checker checks on every cycle the properties that need no timing knowledge: the two strobes are never low together, only one area's enables are active, a strobe occurs only inside an active cycle, bus start follows an accepted request, done is a single pulse, direction and address stay constant within a cycle, and read data changes only right after a read strobe. The exact cycle counts of setup, strobe, wait extension and hold, the enable pattern for each size and address parity, the read capture edge, the snapshot of timing at acceptance and the ignoring of requests while busy depend on the programmed values. Only the bench's behavioural model shows these, and it compares every output on every clock across varied register settings and WAIT patterns.

// File: rtl/mcard_pkg.sv
package mcard_pkg;
  localparam int ADDR_W    = 26;
  localparam int DATA_W    = 16;
  localparam int NUM_AREAS = 2;
  localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1;
  localparam int CNT_W     = 2;
  localparam int LANES     = DATA_W / 8;
  localparam int CFG_W     = 3 * CNT_W;

  // field order matches the register write port: {wait, hold, setup}
  typedef struct packed {
    logic [CNT_W-1:0] wait_cnt;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] setup_cnt;
  } area_cfg_t;

  localparam area_cfg_t CFG_RST = '{wait_cnt: '1, hold_cnt: '1, setup_cnt: '1};

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/mcard_cfg_regs.sv
module mcard_cfg_regs
  import mcard_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AREA_W-1:0]     sel_i,
  input  area_cfg_t             wdata_i,
  output area_cfg_t [NUM_AREAS-1:0] cfg_o
);
  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    area_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= CFG_RST;
      end else if (we_i && (sel_i == AREA_W'(a))) begin
        cfg_q <= wdata_i;
      end
    end
    assign cfg_o[a] = cfg_q;
  end
endmodule

// File: rtl/mcard_seq.sv
module mcard_seq
  import mcard_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  area_cfg_t cfg_i,
  input  logic      wait_i,
  output phase_e    phase_o,
  output logic      first_o,
  output logic      accept_o,
  output logic      cap_o,
  output logic      done_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  area_cfg_t        tim_q;
  logic             first_q, done_q, fin;

  assign accept_o = (phase_q == PH_IDLE) && req_valid_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cap_o   = 1'b0;
    fin     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid_i) begin
          if (cfg_i.setup_cnt != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = cfg_i.setup_cnt - 1'b1;
          end else begin
            phase_d = PH_STROBE;
            cnt_d   = cfg_i.wait_cnt;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = tim_q.wait_cnt;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!wait_i) begin
          // wait_i only matters in the last strobe cycle
          cap_o = 1'b1;
          if (tim_q.hold_cnt != '0) begin
            phase_d = PH_HOLD;
            cnt_d   = tim_q.hold_cnt - 1'b1;
          end else begin
            phase_d = PH_IDLE;
            fin     = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          fin     = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tim_q   <= CFG_RST;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      first_q <= accept_o;
      done_q  <= fin;
      if (accept_o) tim_q <= cfg_i;
    end
  end

  assign phase_o = phase_q;
  assign first_o = first_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mcard_pin_drv.sv
module mcard_pin_drv
  import mcard_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          accept_i,
  input  logic [AREA_W-1:0]             area_i,
  input  logic                          write_i,
  input  logic                          size16_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  phase_e                        phase_i,
  input  logic                          first_i,
  input  logic                          cap_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [ADDR_W-1:0]             bus_addr_o,
  output logic [NUM_AREAS-1:0][LANES-1:0] ce_n_o,
  output logic                          rd_n_o,
  output logic                          we_n_o,
  output logic                          bs_n_o,
  output logic                          rdwr_o,
  output logic [DATA_W-1:0]             data_o,
  output logic                          data_oe_o,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [AREA_W-1:0] area_q;
  logic              wr_q, sz16_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  lane_en;
  logic              active, strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      area_q  <= '0;
      wr_q    <= 1'b0;
      sz16_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      area_q  <= area_i;
      wr_q    <= write_i;
      sz16_q  <= size16_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (cap_i && !wr_q)  rdata_q <= data_i;
  end

  assign active  = (phase_i != PH_IDLE);
  assign strobe  = (phase_i == PH_STROBE);
  assign lane_en = sz16_q ? {LANES{1'b1}} : (addr_q[0] ? LANES'(2) : LANES'(1));

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_ce
    assign ce_n_o[a] = (active && (area_q == AREA_W'(a))) ? ~lane_en : {LANES{1'b1}};
  end

  assign bus_addr_o = addr_q;
  assign rd_n_o     = !(strobe && !wr_q);
  assign we_n_o     = !(strobe && wr_q);
  assign bs_n_o     = !first_i;
  assign rdwr_o     = active ? !wr_q : 1'b1;
  assign data_o     = wdata_q;
  assign data_oe_o  = active && wr_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/mcard_bus_ctrl.sv
module mcard_bus_ctrl
  import mcard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_area_i,
  input  logic              req_write_i,
  input  logic              req_size16_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [LANES-1:0]  ce_a_n_o,
  output logic [LANES-1:0]  ce_b_n_o,
  output logic              rd_n_o,
  output logic              we_n_o,
  output logic              bs_n_o,
  output logic              rdwr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wait_i
);
  area_cfg_t [NUM_AREAS-1:0]            cfg_all;
  area_cfg_t                            cfg_sel;
  phase_e                               phase;
  logic                                 first, accept, cap;
  logic [NUM_AREAS-1:0][LANES-1:0]      ce_n;

  mcard_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (AREA_W'(cfg_sel_i)),
    .wdata_i (area_cfg_t'(cfg_wdata_i)),
    .cfg_o   (cfg_all)
  );

  assign cfg_sel = cfg_all[req_area_i];

  mcard_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .cfg_i       (cfg_sel),
    .wait_i      (wait_i),
    .phase_o     (phase),
    .first_o     (first),
    .accept_o    (accept),
    .cap_o       (cap),
    .done_o      (done_o)
  );

  mcard_pin_drv u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .area_i     (AREA_W'(req_area_i)),
    .write_i    (req_write_i),
    .size16_i   (req_size16_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .phase_i    (phase),
    .first_i    (first),
    .cap_i      (cap),
    .data_i     (data_i),
    .bus_addr_o (bus_addr_o),
    .ce_n_o     (ce_n),
    .rd_n_o     (rd_n_o),
    .we_n_o     (we_n_o),
    .bs_n_o     (bs_n_o),
    .rdwr_o     (rdwr_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .rdata_o    (rdata_o)
  );

  assign req_ready_o = (phase == PH_IDLE);
  assign ce_a_n_o    = ce_n[0];
  assign ce_b_n_o    = ce_n[1];
endmodule

// File: rtl/mcard_bus_ctrl_chk.sv
module mcard_bus_ctrl_chk
  import mcard_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [LANES-1:0]  ce_a_n_o,
  input logic [LANES-1:0]  ce_b_n_o,
  input logic              rd_n_o,
  input logic              we_n_o,
  input logic              bs_n_o,
  input logic              rdwr_o
);
  logic active;
  assign active = !((&ce_a_n_o) && (&ce_b_n_o));

  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !we_n_o));

  a_r9_one_area: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&ce_a_n_o) || (&ce_b_n_o));

  a_r6_strobe_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !we_n_o) |-> active);

  a_r3_start_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |-> $past(req_valid_i && req_ready_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_busy_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> active);

  a_r12_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active)) |-> ($stable(rdwr_o) && $stable(bus_addr_o)));

  a_r7_rdata_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(!rd_n_o));
endmodule

bind mcard_bus_ctrl mcard_bus_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .bus_addr_o  (bus_addr_o),
  .ce_a_n_o    (ce_a_n_o),
  .ce_b_n_o    (ce_b_n_o),
  .rd_n_o      (rd_n_o),
  .we_n_o      (we_n_o),
  .bs_n_o      (bs_n_o),
  .rdwr_o      (rdwr_o)
);

// File: tb/tb_mcard_bus_ctrl.sv
`timescale 1ns/1ps
module tb_mcard_bus_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [5:0]  cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0, req_area_i = 1'b0, req_write_i = 1'b0, req_size16_i = 1'b0;
  logic [25:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_ready_o, done_o;
  logic [15:0] rdata_o, data_o;
  logic [25:0] bus_addr_o;
  logic [1:0]  ce_a_n_o, ce_b_n_o;
  logic        rd_n_o, we_n_o, bs_n_o, rdwr_o, data_oe_o;
  logic [15:0] data_i = 16'h3c5a;
  logic        wait_i = 1'b0;

  always #2 clk_i = ~clk_i;

  mcard_bus_ctrl dut (.*);

  int checks = 0, failures = 0;
  int wait_budget = 0;

  // reference model state
  int          q[$];          // 1 setup, 2 strobe, 3 hold
  bit          m_first = 0, m_done = 0, m_wr = 0, m_sz = 0, m_area = 0;
  logic [25:0] m_addr = '0;
  logic [15:0] m_wdata = '0, m_rdata = '0;
  int          m_set[2] = '{3, 3}, m_hld[2] = '{3, 3}, m_wt[2] = '{3, 3};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) if (rst_ni) begin
    m_first = 0;
    m_done  = 0;
    if (q.size() != 0) begin
      if (q[0] == 2 && (q.size() == 1 || q[1] != 2)) begin
        if (!wait_i) begin  // R5 extension when high
          if (!m_wr) m_rdata = data_i;
          void'(q.pop_front());
        end
      end else begin
        void'(q.pop_front());
      end
      if (q.size() == 0) m_done = 1;
    end else if (req_valid_i) begin
      m_area = req_area_i; m_wr = req_write_i; m_sz = req_size16_i;
      m_addr = req_addr_i; m_wdata = req_wdata_i; m_first = 1;
      for (int k = 0; k < m_set[m_area]; k++) q.push_back(1);
      for (int k = 0; k <= m_wt[m_area]; k++) q.push_back(2);
      for (int k = 0; k < m_hld[m_area]; k++) q.push_back(3);
    end
    if (cfg_we_i) begin  // R1 field positions
      m_set[cfg_sel_i] = int'(cfg_wdata_i[1:0]);
      m_hld[cfg_sel_i] = int'(cfg_wdata_i[3:2]);
      m_wt[cfg_sel_i]  = int'(cfg_wdata_i[5:4]);
    end
    if (wait_i && wait_budget > 0) wait_budget--;
  end

  task automatic compare_all();
    bit act;
    int ph;
    logic [1:0] lane, ea, eb;
    act  = (q.size() != 0);
    ph   = act ? q[0] : 0;
    lane = m_sz ? 2'b11 : (m_addr[0] ? 2'b10 : 2'b01);
    ea   = (act && !m_area) ? ~lane : 2'b11;
    eb   = (act && m_area) ? ~lane : 2'b11;
    chk(rd_n_o == !(ph == 2 && !m_wr), act ? "R4 rd_n" : "R11 rd_n", rd_n_o, !(ph == 2 && !m_wr));
    chk(we_n_o == !(ph == 2 && m_wr), act ? "R4 we_n" : "R11 we_n", we_n_o, !(ph == 2 && m_wr));
    chk(bs_n_o == !m_first, "R3 bs_n", bs_n_o, !m_first);
    chk(ce_a_n_o == ea, act ? "R9 ce_a" : "R11 ce_a", ce_a_n_o, ea);
    chk(ce_b_n_o == eb, act ? "R9 ce_b" : "R11 ce_b", ce_b_n_o, eb);
    chk(data_oe_o == (act && m_wr), "R6 data_oe", data_oe_o, act && m_wr);
    chk(rdwr_o == (act ? !m_wr : 1'b1), "R12 rdwr", rdwr_o, act ? !m_wr : 1'b1);
    chk(req_ready_o == !act, "R2 ready", req_ready_o, !act);
    chk(done_o == m_done, "R8 done", done_o, m_done);
    chk(rdata_o == m_rdata, "R7 rdata", rdata_o, m_rdata);
    if (act) chk(bus_addr_o == m_addr, "R3 addr", bus_addr_o, m_addr);
    if (act && m_wr) chk(data_o == m_wdata, "R6 wdata", data_o, m_wdata);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) compare_all();
    wait_i = (wait_budget > 0) && (!rd_n_o || !we_n_o);
    data_i = data_i + 16'h1357;
  end

  task automatic write_cfg(input bit area, input int s, input int h, input int w);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_sel_i = area;
    cfg_wdata_i = {2'(w), 2'(h), 2'(s)};
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic start(input bit area, input bit wr, input bit sz, input logic [25:0] a,
                       input logic [15:0] d, input int wbud);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_area_i = area; req_write_i = wr; req_size16_i = sz;
    req_addr_i = a; req_wdata_i = d; req_valid_i = 1; wait_budget = wbud;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11 idle outputs under reset
    repeat (3) @(negedge clk_i);
    chk(rd_n_o && we_n_o && bs_n_o, "R11 reset strobes", {rd_n_o, we_n_o, bs_n_o}, 3'b111);
    chk(ce_a_n_o == 2'b11 && ce_b_n_o == 2'b11, "R11 reset ce", {ce_a_n_o, ce_b_n_o}, 4'hf);
    chk(!data_oe_o && rdwr_o && !done_o, "R11 reset misc", {data_oe_o, rdwr_o, done_o}, 3'b010);
    chk(rdata_o == 16'h0, "R7 reset rdata", rdata_o, 16'h0);
    rst_ni = 1;

    // R1 reset timing 3/3/3 on both areas
    start(0, 0, 1, 26'h0123456, 16'h0, 0);
    start(1, 1, 1, 26'h2000010, 16'hbeef, 0);

    // R1 programmed timing, R9 enable patterns
    write_cfg(0, 0, 0, 0);
    write_cfg(1, 2, 1, 1);
    start(0, 0, 0, 26'h0000100, 16'h0, 0);   // 8-bit even
    start(0, 1, 0, 26'h0000101, 16'h1122, 0); // 8-bit odd
    start(1, 0, 0, 26'h0000203, 16'h0, 0);
    start(1, 1, 1, 26'h0000204, 16'h3344, 0);

    // R5 WAIT extension, with and without software waits
    start(0, 0, 1, 26'h0000300, 16'h0, 3);
    start(1, 0, 1, 26'h0000302, 16'h0, 4);
    write_cfg(0, 1, 2, 3);
    start(0, 1, 1, 26'h0000304, 16'h5566, 2);

    // R2 request while busy is ignored
    write_cfg(0, 3, 3, 3);
    start(0, 0, 1, 26'h0000400, 16'h0, 0);
    req_area_i = 1; req_write_i = 1; req_addr_i = 26'h3ffffff; req_valid_i = 1;
    repeat (3) @(negedge clk_i);
    req_valid_i = 0;

    // R10 register write during a cycle
    write_cfg(1, 3, 3, 3);
    start(1, 0, 1, 26'h0000500, 16'h0, 0);
    cfg_we_i = 1; cfg_sel_i = 1; cfg_wdata_i = 6'b000000;
    @(negedge clk_i);
    cfg_we_i = 0;
    start(1, 0, 1, 26'h0000502, 16'h0, 0);

    // varied settings, back-to-back cycles
    for (int i = 0; i < 24; i++) begin
      write_cfg(i[0], i % 4, (i / 2) % 4, (i / 3) % 4);
      start(i[0], i[1], i[2], 26'(32'h00abcde + i * 32'h31c7), 16'(32'h9e37 * (i + 1)), i % 5);
      start(!i[0], !i[1], i[3], 26'(32'h1000001 + i * 32'h0103), 16'(i * 32'h0f0f), 0);
    end

    repeat (30) @(negedge clk_i);
    finish_run();
  end
endmodule